// File: doc/BRIEF.md
# Split integer-fraction charge accumulator

This block integrates a stream of signed current samples into a running charge total. The total is a 64-bit fixed-point value: a signed integer part in the upper half and an unsigned fraction in the lower half. Each accepted sample is multiplied by a scale constant, sign-extended and added to the whole 64-bit value. There are two scale constants. One is for the fast sampling rate (one sample per 250 ms) and one is for the slow, low-power rate (one sample per 4 s). A rate select input picks the constant for each sample. Carries and borrows cross from the fraction into the integer, so discharge currents lower the total through zero into negative values.

After reset or a clear, the fraction starts at one half of an integer unit. The integer output therefore reads as the rounded charge, not the truncated charge. Next to the charge, a saturating counter counts one-second ticks and so gives the time over which charge has been integrated. A clear command zeroes the integer part and the time counter and presets the fraction, all in one cycle.

Top module: `qacc_top`

## Requirements
- R1: After synchronous active-low reset, the integer output is 0, the fraction output is 0x8000_0000 (one half) and the seconds output is 0.
- R2: A sample accepted with the rate select at 0 adds sample × SCALE_NORM (default 0x0400_0000, that is 1/64 of an integer unit) to the 64-bit {integer, fraction} value. The new total appears two clock edges after the edge that samples the valid strobe, and not earlier.
- R3: A sample accepted with the rate select at 1 adds sample × SCALE_SLOW (default 0x4000_0000, that is 1/4 unit).
- R4: When the fraction sum overflows 32 bits, the integer part gains one and the fraction keeps the low 32 bits of the sum.
- R5: A negative sample (two's complement) lowers the total, with a borrow from the integer when the fraction would go below zero.
- R6: A clear presets the outputs to the R1 values on the next edge. Clear has priority over a tick and over a sample in the same cycle. A sample whose valid strobe came one cycle before the clear is also discarded.
- R7: Each one-second tick raises the seconds output by one, visible after the edge that samples the tick.
- R8: The seconds counter holds at its all-ones value and does not wrap.
- R9: With no valid strobe, the charge outputs stay unchanged, even when the rate select changes.
- R10: Samples presented on consecutive cycles are each accumulated exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed current sample |
| sample_valid_i | input | 1 | Sample strobe, one cycle per sample |
| rate_sel_i | input | 1 | 0: fast-rate scale, 1: slow-rate scale |
| sec_tick_i | input | 1 | One-second tick, one cycle wide |
| clear_i | input | 1 | Preset the charge and zero the seconds count |
| charge_int_o | output | INT_W | Signed integer part of the charge |
| charge_frac_o | output | FRAC_W | Unsigned fractional part of the charge |
| elapsed_sec_o | output | SEC_W | Saturating count of seconds integrated |

## Verification
A charge result is due two edges after the edge that samples the valid strobe: one edge for the scaling register and one for the accumulator. A seconds or clear result is due after a single edge. Each sample test therefore checks the outputs both one cycle and two cycles after the strobe. The one-cycle check confirms that nothing has moved yet, and the two-cycle check confirms the exact new total. Inputs change on falling edges and outputs are read on the falling edge after the edge where they are due, so every check lands at a known cycle.

// File: rtl/qacc_pkg.sv
// Shared definitions for the charge accumulator.
// Assumes: used by every qacc_* module; holds no state.
package qacc_pkg;

    // Sample-rate select encoding
    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    // Fraction preset: one half of an integer unit
    function automatic logic [63:0] half_unit(input int frac_w);
        logic [63:0] v;
        v = 64'd1 << (frac_w - 1);
        return v;
    endfunction

endpackage

// File: rtl/qacc_scaler.sv
// Scales one signed sample by the rate-dependent constant and registers the
// sign-extended addend for the accumulator (one cycle of latency).
// Assumes: SAMPLE_W + SCALE_W + 1 <= ACC_W; flush_i drops any value in flight.
module qacc_scaler
    import qacc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SCALE_W  = 32,
    parameter int ACC_W    = 64,
    parameter logic [SCALE_W-1:0] SCALE_FAST = 32'h0400_0000,
    parameter logic [SCALE_W-1:0] SCALE_SLOW = 32'h4000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                valid_i,
    input  logic                rate_i,
    output logic [ACC_W-1:0]    addend_o,
    output logic                addend_v_o
);
    localparam int PROD_W = SAMPLE_W + SCALE_W + 1;

    logic [SCALE_W-1:0]       scale;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         prod_ext;

    // Pick the scale constant for the current rate
    always_comb begin
        scale = (rate_e'(rate_i) == RATE_SLOW) ? SCALE_SLOW : SCALE_FAST;
    end

    // Signed sample times unsigned scale
    always_comb begin
        prod = PROD_W'($signed(sample_i)) * PROD_W'($signed({1'b0, scale}));
    end

    // Sign-extend the product to the accumulator width
    generate
        if (PROD_W < ACC_W) begin : g_ext
            assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
        end else begin : g_same
            assign prod_ext = ACC_W'(prod);
        end
    endgenerate

    // Register the addend and its strobe; flush or reset empties the stage
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            addend_v_o <= 1'b0;
            addend_o   <= '0;
        end else begin
            addend_v_o <= valid_i;
            if (valid_i) begin
                addend_o <= prod_ext;
            end
        end
    end

    // R6: a flushed cycle never carries a sample forward
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !addend_v_o);

    // R10: each accepted strobe produces exactly one addend strobe
    a_r10_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i) |=> (addend_v_o == $past(valid_i)));

endmodule

// File: rtl/qacc_integrator.sv
// Adds a 64-bit two's-complement addend into the {integer, fraction} total,
// using a split adder: fraction sum with carry-out, then integer sum with
// carry-in. Clear or reset presets the fraction to one half.
// Assumes: the addend is already sign-extended to INT_W + FRAC_W bits.
module qacc_integrator
    import qacc_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int FRAC_W = 32,
    localparam int ACC_W = INT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [ACC_W-1:0]  addend_i,
    input  logic              add_v_i,
    output logic [INT_W-1:0]  int_o,
    output logic [FRAC_W-1:0] frac_o
);
    localparam logic [FRAC_W-1:0] FRAC_HALF = FRAC_W'(half_unit(FRAC_W));

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   frac_sum;
    logic              carry;
    logic [INT_W-1:0]  int_sum;

    // Fraction half of the adder with its carry out
    always_comb begin
        frac_sum = {1'b0, frac_q} + {1'b0, addend_i[FRAC_W-1:0]};
        carry    = frac_sum[FRAC_W];
    end

    // Integer half of the adder; the carry-in completes the borrow or carry
    always_comb begin
        int_sum = int_q + addend_i[ACC_W-1:FRAC_W] + {{(INT_W-1){1'b0}}, carry};
    end

    // Total register: preset on reset or clear, accumulate on strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            int_q  <= '0;
            frac_q <= FRAC_HALF;
        end else if (add_v_i) begin
            int_q  <= int_sum;
            frac_q <= frac_sum[FRAC_W-1:0];
        end
    end

    assign int_o  = int_q;
    assign frac_o = frac_q;

    // R6: clear leaves the rounding preset behind
    a_r6_clear_preset: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (int_o == '0 && frac_o == FRAC_HALF));

    // R9: no strobe, no change
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_v_i && !clr_i) |=> ($stable(int_o) && $stable(frac_o)));

    // R5: a negative addend with a zero fraction part lowers the integer
    a_r5_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (add_v_i && !clr_i && addend_i[ACC_W-1] && addend_i[FRAC_W-1:0] == '0)
        |=> (int_o != $past(int_o)) && $stable(frac_o));

endmodule

// File: rtl/qacc_seconds.sv
// Saturating counter of one-second ticks since the last clear.
// Assumes: tick_i is one cycle wide; clear has priority over a tick.
module qacc_seconds #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [SEC_W-1:0] sec_o
);
    localparam logic [SEC_W-1:0] SEC_MAX = '1;

    logic [SEC_W-1:0] sec_q;

    // Count ticks, stop at all ones, zero on clear or reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sec_q <= '0;
        end else if (tick_i && sec_q != SEC_MAX) begin
            sec_q <= sec_q + 1'b1;
        end
    end

    assign sec_o = sec_q;

    // R7: a tick below the limit advances by exactly one
    a_r7_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && sec_o != SEC_MAX) |=> (sec_o == $past(sec_o) + 1'b1));

    // R8: the limit is held
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o == SEC_MAX && !clr_i) |=> (sec_o == SEC_MAX));

    // R6: clear wins over a tick
    a_r6_clear_sec: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sec_o == '0));

endmodule

// File: rtl/qacc_top.sv
// Charge accumulator top: scaler stage, split integrator and seconds counter.
// Charge results land two edges after a sample strobe; seconds and clear
// take effect after one edge. Clear also flushes the scaler stage.
// Assumes: synchronous active-low reset; single clock.
module qacc_top #(
    parameter int SAMPLE_W = 16,
    parameter int INT_W    = 32,
    parameter int FRAC_W   = 32,
    parameter int SEC_W    = 32,
    parameter int SCALE_W  = 32,
    parameter logic [SCALE_W-1:0] SCALE_NORM = 32'h0400_0000,
    parameter logic [SCALE_W-1:0] SCALE_SLOW = 32'h4000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_valid_i,
    input  logic                rate_sel_i,
    input  logic                sec_tick_i,
    input  logic                clear_i,
    output logic [INT_W-1:0]    charge_int_o,
    output logic [FRAC_W-1:0]   charge_frac_o,
    output logic [SEC_W-1:0]    elapsed_sec_o
);
    localparam int ACC_W = INT_W + FRAC_W;

    logic [ACC_W-1:0] addend;
    logic             addend_v;

    // Stage 1: scale and register
    qacc_scaler #(
        .SAMPLE_W  (SAMPLE_W),
        .SCALE_W   (SCALE_W),
        .ACC_W     (ACC_W),
        .SCALE_FAST(SCALE_NORM),
        .SCALE_SLOW(SCALE_SLOW)
    ) u_scaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (clear_i),
        .sample_i  (sample_i),
        .valid_i   (sample_valid_i),
        .rate_i    (rate_sel_i),
        .addend_o  (addend),
        .addend_v_o(addend_v)
    );

    // Stage 2: accumulate
    qacc_integrator #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W)
    ) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clear_i),
        .addend_i(addend),
        .add_v_i (addend_v),
        .int_o   (charge_int_o),
        .frac_o  (charge_frac_o)
    );

    // Elapsed-time counter
    qacc_seconds #(
        .SEC_W(SEC_W)
    ) u_sec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .tick_i(sec_tick_i),
        .sec_o (elapsed_sec_o)
    );

    // R2: a strobe with no clear around it moves nothing on the first edge
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && !clear_i && !addend_v) |=>
            ($stable(charge_int_o) && $stable(charge_frac_o)));

endmodule

// File: tb/sim_qacc_top.sv
`timescale 1ns/1ps
module sim_qacc_top;
    localparam int SW = 16;
    localparam int TW = 4;
    localparam logic [31:0] K_NORM = 32'h0400_0000;
    localparam logic [31:0] K_SLOW = 32'h4000_0000;
    localparam logic [63:0] PRESET = 64'h0000_0000_8000_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst_n;
    logic signed [SW-1:0] smp;
    logic                 smp_v, rate, tick, clr;
    logic [31:0]          q_int, q_frac;
    logic [TW-1:0]        q_sec;

    qacc_top #(.SEC_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(smp), .sample_valid_i(smp_v),
        .rate_sel_i(rate), .sec_tick_i(tick), .clear_i(clr),
        .charge_int_o(q_int), .charge_frac_o(q_frac), .elapsed_sec_o(q_sec)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] model;
    int model_sec;

    function automatic logic [63:0] scaled(input logic signed [SW-1:0] s, input logic r);
        longint p;
        p = longint'(s) * longint'({32'h0, (r ? K_SLOW : K_NORM)});
        return p;
    endfunction

    task automatic check(input string tag, input string what);
        checks++;
        if ({q_int, q_frac} !== model || int'(q_sec) != model_sec) begin
            errors++;
            $display("FAIL %s %s: got int=%h frac=%h sec=%0d, expected int=%h frac=%h sec=%0d",
                     tag, what, q_int, q_frac, q_sec, model[63:32], model[31:0], model_sec);
        end
    endtask

    task automatic do_sample(input logic signed [SW-1:0] s, input logic r, input string tag);
        @(negedge clk); smp = s; rate = r; smp_v = 1'b1;
        @(negedge clk); smp_v = 1'b0;
        check(tag, "unchanged one cycle after strobe");
        @(negedge clk);
        model = model + scaled(s, r);
        check(tag, "total two cycles after strobe");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = PRESET; model_sec = 0;
        check("R1", "reset state");
    endtask

    task automatic t_scaling();
        do_sample(16'sd3, 1'b0, "R2");       // frac 0x8C00_0000
        do_sample(16'sd2, 1'b1, "R3_R4");    // fraction overflows into integer
        do_sample(-16'sd5, 1'b1, "R5");      // borrow below zero
        do_sample(-16'sd32768, 1'b0, "R5");
        do_sample(16'sd32767, 1'b1, "R2_R3");
    endtask

    task automatic t_burst();
        logic signed [SW-1:0] vals [4] = '{16'sd1000, -16'sd7, 16'sd32767, 16'sd129};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); smp = vals[i]; rate = i[0]; smp_v = 1'b1;
            model = model + scaled(vals[i], i[0]);
        end
        @(negedge clk); smp_v = 1'b0;
        @(negedge clk);
        check("R10", "back-to-back burst");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); rate = ~rate; smp = 16'sd555;
        end
        @(negedge clk);
        check("R9", "no strobe, rate toggling");
    endtask

    task automatic t_ticks();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            model_sec++;
            check("R7", "one tick");
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); tick = 1'b1;
            if (model_sec < 15) model_sec++;
        end
        @(negedge clk); tick = 1'b0;
        check("R8", "saturated seconds");
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R8", "tick at limit");
    endtask

    task automatic t_clear();
        @(negedge clk); smp = 16'sd100; rate = 1'b1; smp_v = 1'b1; tick = 1'b1; clr = 1'b1;
        @(negedge clk); smp_v = 1'b0; tick = 1'b0; clr = 1'b0;
        model = PRESET; model_sec = 0;
        check("R6", "clear with sample and tick");
        repeat (2) @(negedge clk);
        check("R6", "sample with clear discarded");
        do_sample(16'sd50, 1'b0, "R2");
        @(negedge clk); smp = 16'sd77; smp_v = 1'b1;
        @(negedge clk); smp_v = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model = PRESET;
        check("R6", "clear after in-flight sample");
        repeat (2) @(negedge clk);
        check("R6", "in-flight sample discarded");
    endtask

    initial begin
        rst_n = 1'b0; smp = '0; smp_v = 1'b0; rate = 1'b0; tick = 1'b0; clr = 1'b0;
        model = PRESET; model_sec = 0;
        t_reset();
        t_scaling();
        t_burst();
        t_idle();
        t_ticks();
        t_clear();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule